// File: doc/BRIEF.md
# External Program Memory Address Interface

This block sits between a microcontroller's multiplexed bus and a bank of external program memory devices. During an external fetch the low address byte appears briefly on the shared bus. The block holds it in a register that follows the bus while the address-latch strobe is high and freezes when the strobe drops. The upper address bits come straight from the low nibble of a port, because they stay valid for the whole fetch. Two of these bits go to the memory address inputs unchanged. The two most significant bits are decoded into active-low chip selects.

The port nibble is time-shared: it carries address bits during the fetch and the port's I/O value at other times. The I/O value is valid at the rising edge of the strobe, so a side register keeps a copy taken at that edge. The surrounding logic can read the I/O state back from that copy. The chip selects only assert while the program-store enable is active. The lowest decode value belongs to on-chip memory and selects nothing. Three 1K external devices plus 1K of internal memory cover 4K words. While a device is selected, its data is driven onto the bus. Otherwise the bus output is released.

Top module: `ext_prog_addr_if`

## Requirements
- R1: While reset (rstN low) is asserted and right after it ends, the latched low address byte (memAddr[7:0]) and the I/O copy (ioNib) are zero.
- R2: On every rising clock edge where aleStrobe is 1, memAddr[7:0] loads the value of busIn.
- R3: On every rising clock edge where aleStrobe is 0, memAddr[7:0] keeps its value.
- R4: memAddr[9:8] equals portNib[1:0] at all times, with no register in between.
- R5: ioNib loads portNib only on a strobe rising edge. This is a clock edge where aleStrobe is 1 and either the previous edge saw it at 0 or reset ended since the previous edge. At every other edge, ioNib holds its value, including while the strobe stays high.
- R6: When psenN is 0, the decode value portNib[3:2] = 1, 2 or 3 drives exactly chipSelN[0], chipSelN[1] or chipSelN[2] low, respectively. Decode value 0 (internal memory) leaves all three high.
- R7: When psenN is 1, all chipSelN bits are 1, whatever the value of portNib.
- R8: busOe is 1 exactly when psenN is 0 and portNib[3:2] is not 0. While busOe is 1, busOut equals memData. While busOe is 0, busOut is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| aleStrobe | input | 1 | Address-latch strobe, active high |
| busIn | input | 8 | Multiplexed bus as driven by the processor |
| portNib | input | 4 | Port low nibble: upper address bits or I/O data |
| psenN | input | 1 | Program-store enable, active low |
| memData | input | 8 | Data returned by the external devices |
| memAddr | output | 10 | Address to the devices: pass bits above latched low byte |
| ioNib | output | 4 | I/O copy of the port nibble, taken at the strobe's rising edge |
| chipSelN | output | 3 | Per-device chip selects, active low |
| busOut | output | 8 | Bus data from the selected device, zero when released |
| busOe | output | 1 | Bus drive enable |

## Verification
The bench builds the block with its default parameters: an 8-bit low byte, a 4-bit port nibble and 2 decode bits, which gives three external selects. With these values, random nibbles reach every decode value, including the internal region, and each device select can appear with the enable both on and off. Strobe runs of random length produce isolated pulses, long high stretches and pulses right after reset, so the I/O copy is tested for both capture and hold.

// File: rtl/ext_prog_addr_pkg.sv
package ext_prog_addr_pkg;
  typedef struct packed {
    logic loadLow;
    logic loadIo;
  } latchCtl_t;
endpackage

// File: rtl/ext_prog_addr_ctrl.sv
module ext_prog_addr_ctrl
  import ext_prog_addr_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      aleStrobe,
  output latchCtl_t ctl
);
  logic strobeSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) strobeSeen <= 1'b0;
    else       strobeSeen <= aleStrobe;
  end

  always_comb begin
    ctl.loadLow = aleStrobe;
    ctl.loadIo  = aleStrobe & ~strobeSeen;
  end
endmodule

// File: rtl/ext_prog_addr_dp.sv
module ext_prog_addr_dp
  import ext_prog_addr_pkg::*;
#(
  parameter int LowW  = 8,
  parameter int PortW = 4,
  parameter int SelW  = 2,
  parameter int DataW = 8,
  localparam int PassW  = PortW - SelW,
  localparam int AddrW  = LowW + PassW,
  localparam int DevCnt = (1 << SelW) - 1
)(
  input  logic             clk,
  input  logic             rstN,
  input  latchCtl_t        ctl,
  input  logic [LowW-1:0]  busIn,
  input  logic [PortW-1:0] portNib,
  input  logic             psenN,
  input  logic [DataW-1:0] memData,
  output logic [AddrW-1:0] memAddr,
  output logic [PortW-1:0] ioNib,
  output logic [DevCnt-1:0] chipSelN,
  output logic [DataW-1:0] busOut,
  output logic             busOe
);
  logic [LowW-1:0] lowByte;
  logic [PortW-1:0] ioCopy;
  logic [SelW-1:0] devCode;
  logic anySel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowByte <= '0;
      ioCopy  <= '0;
    end else begin
      if (ctl.loadLow) lowByte <= busIn;
      if (ctl.loadIo)  ioCopy  <= portNib;
    end
  end

  assign devCode = portNib[PortW-1 -: SelW];
  assign memAddr = {portNib[PassW-1:0], lowByte};
  assign ioNib   = ioCopy;

  for (genvar k = 0; k < DevCnt; k++) begin : g_sel
    assign chipSelN[k] = ~(~psenN && (devCode == SelW'(k + 1)));
  end

  assign anySel = ~psenN && (devCode != '0);
  assign busOe  = anySel;
  assign busOut = anySel ? memData : '0;
endmodule

// File: rtl/ext_prog_addr_if.sv
module ext_prog_addr_if
  import ext_prog_addr_pkg::*;
#(
  parameter int LowW  = 8,
  parameter int PortW = 4,
  parameter int SelW  = 2,
  parameter int DataW = 8,
  localparam int PassW  = PortW - SelW,
  localparam int AddrW  = LowW + PassW,
  localparam int DevCnt = (1 << SelW) - 1
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              aleStrobe,
  input  logic [LowW-1:0]   busIn,
  input  logic [PortW-1:0]  portNib,
  input  logic              psenN,
  input  logic [DataW-1:0]  memData,
  output logic [AddrW-1:0]  memAddr,
  output logic [PortW-1:0]  ioNib,
  output logic [DevCnt-1:0] chipSelN,
  output logic [DataW-1:0]  busOut,
  output logic              busOe
);
  latchCtl_t ctl;

  ext_prog_addr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .aleStrobe(aleStrobe), .ctl(ctl)
  );

  ext_prog_addr_dp #(
    .LowW(LowW), .PortW(PortW), .SelW(SelW), .DataW(DataW)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .busIn(busIn), .portNib(portNib),
    .psenN(psenN), .memData(memData), .memAddr(memAddr), .ioNib(ioNib),
    .chipSelN(chipSelN), .busOut(busOut), .busOe(busOe)
  );
endmodule

// File: rtl/ext_prog_addr_chk.sv
module ext_prog_addr_chk #(
  parameter int LowW = 8, parameter int PortW = 4, parameter int SelW = 2,
  parameter int DataW = 8, parameter int AddrW = 10, parameter int DevCnt = 3
)(
  input logic clk, input logic rstN, input logic aleStrobe,
  input logic [LowW-1:0] busIn, input logic [PortW-1:0] portNib,
  input logic psenN, input logic [DataW-1:0] memData,
  input logic [AddrW-1:0] memAddr, input logic [PortW-1:0] ioNib,
  input logic [DevCnt-1:0] chipSelN, input logic [DataW-1:0] busOut,
  input logic busOe
);
  // R2
  low_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    aleStrobe |=> memAddr[LowW-1:0] == $past(busIn));
  // R3
  low_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !aleStrobe |=> $stable(memAddr[LowW-1:0]));
  // R5
  io_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !aleStrobe |=> $stable(ioNib));
  // R6
  one_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~chipSelN));
  // R7
  no_sel_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    psenN |-> (&chipSelN));
  // R8
  drive_needs_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    busOe |-> (!psenN && !(&chipSelN)));
endmodule

bind ext_prog_addr_if ext_prog_addr_chk #(
  .LowW(LowW), .PortW(PortW), .SelW(SelW), .DataW(DataW),
  .AddrW(AddrW), .DevCnt(DevCnt)
) u_chk (.*);

// File: tb/ext_prog_addr_if_test.sv
`timescale 1ns/1ps
module ext_prog_addr_if_test;
  localparam int LowW = 8, PortW = 4, SelW = 2, DataW = 8;
  localparam int PassW = PortW - SelW, AddrW = LowW + PassW;
  localparam int DevCnt = (1 << SelW) - 1;

  logic clk = 0, rstN = 0, aleStrobe = 0, psenN = 1;
  logic [LowW-1:0] busIn = '0;
  logic [PortW-1:0] portNib = '0;
  logic [DataW-1:0] memData = '0;
  logic [AddrW-1:0] memAddr;
  logic [PortW-1:0] ioNib;
  logic [DevCnt-1:0] chipSelN;
  logic [DataW-1:0] busOut;
  logic busOe;

  int checks = 0, fails = 0;
  bit done = 0;
  int refLow = 0, refIo = 0, prevStrobe = 0, lastLoad = 0;

  always #4 clk = ~clk;

  ext_prog_addr_if uut (.*);

  // behavioural reference, updated at the same edge as the design
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refLow = 0; refIo = 0; prevStrobe = 0; lastLoad = 0;
    end else begin
      lastLoad = aleStrobe;
      if (aleStrobe) refLow = busIn;
      if (aleStrobe && !prevStrobe) refIo = portNib;
      prevStrobe = aleStrobe;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    int code, expSel, expOe, expBus;
    code = portNib >> PassW;
    expSel = (1 << DevCnt) - 1;
    if (!psenN && code != 0) expSel = expSel & ~(1 << (code - 1));
    expOe = (!psenN && code != 0) ? 1 : 0;
    expBus = expOe ? memData : 0;
    chk(memAddr[LowW-1:0] == refLow, lastLoad ? "R2" : "R3", memAddr[LowW-1:0], refLow);
    chk(memAddr[AddrW-1:LowW] == portNib[PassW-1:0], "R4", memAddr[AddrW-1:LowW], portNib[PassW-1:0]);
    chk(ioNib == refIo, "R5", ioNib, refIo);
    chk(chipSelN == expSel, psenN ? "R7" : "R6", chipSelN, expSel);
    chk(busOe == expOe && busOut == expBus, "R8", {busOe, busOut}, {expOe[0], expBus[DataW-1:0]});
  endtask

  // at each falling edge: compare, then drive the next inputs
  task automatic stepCycle(input bit s, input int b, input int p, input bit e, input int d);
    @(negedge clk);
    compareAll();
    aleStrobe = s; busIn = b; portNib = p; psenN = e; memData = d;
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    busIn = 8'hA5; portNib = 4'hF; aleStrobe = 1;
    repeat (2) @(negedge clk);
    // R1 reset state
    chk(memAddr[LowW-1:0] == 0, "R1", memAddr[LowW-1:0], 0);
    chk(ioNib == 0, "R1", ioNib, 0);
    aleStrobe = 0;
    @(negedge clk); rstN = 1;
    chk(memAddr[LowW-1:0] == 0 && ioNib == 0, "R1", {memAddr[LowW-1:0], ioNib}, 0);
    // R6 every decode value with the enable on, then R7 with it off
    for (int c = 0; c < 4; c++) stepCycle(0, 8'h11 * c, c << 2, 0, 8'h3C + c);
    for (int c = 0; c < 4; c++) stepCycle(0, 0, c << 2, 1, 8'hC3);
    // R5 long strobe: only the first edge captures
    stepCycle(1, 8'h5A, 4'h9, 1, 0);
    stepCycle(1, 8'h6B, 4'h6, 1, 0);
    stepCycle(1, 8'h7C, 4'h3, 1, 0);
    stepCycle(0, 8'hFF, 4'hC, 1, 0);
    stepCycle(0, 8'h00, 4'h1, 0, 8'h99);
    // random traffic
    for (int i = 0; i < 3000; i++)
      stepCycle(($urandom % 3) == 0, $urandom, $urandom, $urandom, $urandom);
    // reset mid-run and strobe right after it (R1, R5)
    @(negedge clk); rstN = 0; aleStrobe = 1; portNib = 4'h7;
    @(negedge clk); chk(ioNib == 0 && memAddr[LowW-1:0] == 0, "R1", ioNib, 0);
    rstN = 1;
    for (int i = 0; i < 6; i++) stepCycle(1, 8'h20 + i, i + 2, 1, 0);
    stepCycle(0, 0, 0, 1, 0);
    @(negedge clk); compareAll();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule